// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock into the timing strobes that a serial receiver and transmitter need. It emits a 16x tick: a train of pulses, each one reference cycle wide, whose average rate is sixteen times the chosen baud rate. It also emits a bit tick on every sixteenth 16x tick. The divisor is the reference frequency over sixteen times the baud rate. It is given as an integer part and a fractional part, which is expressed in 64ths. A larger divisor gives slower ticks.

The integer part sets the base spacing between 16x ticks. On every tick, the fractional part is added into a small accumulator. A period whose addition carries out is made one reference cycle longer. Over any 64 consecutive ticks, the total length therefore equals 64 times the integer part plus the fractional field. This gives an exact average rate, not just a rounded integer division.

A load strobe captures a new divisor and restarts all timing from zero. An enable input pauses the generator without losing its position.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is held and after it is released, with no divisor loaded, neither tick is ever asserted (the held integer part resets to zero).
- R2: With the fractional field zero and integer part I >= 1, the 16x tick repeats every I enabled reference cycles. The first tick comes I enabled cycles after the load cycle.
- R3: With integer part I and fractional field F (in 64ths), the n-th 16x tick after a load ends enabled cycle n*I + floor(n*F/64), counted from the cycle after the load. Every period is therefore I or I+1 cycles long, and 64 ticks span exactly 64*I+F enabled cycles.
- R4: The bit tick is asserted only together with a 16x tick, on the 16th, 32nd, 48th, ... 16x tick after a load.
- R5: While the held integer part is zero, no tick is produced.
- R6: While the enable input is low, no tick is produced and the timing position is frozen. When enable returns, counting continues from where it stopped.
- R7: A cycle with the load strobe high produces no tick. It clears the period counter, the fractional accumulator and the 16-tick count, so the first tick after it follows the new divisor alone.
- R8: With an integer part of 2 or more, each 16x tick lasts exactly one reference cycle. With an integer part of 1 and fraction 0, a tick occurs in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| div_int | input | 16 | Integer part of the divisor |
| div_frac | input | 6 | Fractional part of the divisor, in 64ths |
| div_load | input | 1 | Captures div_int and div_frac and restarts timing |
| tick16 | output | 1 | One-cycle pulse at sixteen times the baud rate |
| tick1 | output | 1 | One-cycle pulse on every sixteenth tick16 |

## Verification
The bench targets the fractional carry schedule, using fractions near both ends (1, 21, 32, 63). A design that adds the fraction after the comparison, or that drops the carry, drifts from the closed-form tick instants within one 64-tick cycle. It also covers integer part 1, where a design that needs a spare cycle per period would halve the rate. Integer part 0 is tested because a down-counter design would wrap there and tick every 65536 cycles. The bench pauses enable in mid-period and reloads in mid-period. A design that clears on pause, or that keeps the old accumulator after a reload, shifts every later tick.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              div_load,
  output logic              tick16,
  output logic              tick1
);
  localparam int CNT_W = INT_W + 1;
  localparam int SUB_W = $clog2(OVS);

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [SUB_W-1:0]  sub_q;

  logic [FRAC_W:0]   acc_sum;
  logic [CNT_W-1:0]  period;
  logic              run;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};
  assign period  = {1'b0, int_q} + CNT_W'(acc_sum[FRAC_W]);
  assign run     = en && !div_load && (int_q != '0);
  assign tick16  = run && (cnt_q == period - CNT_W'(1));
  assign tick1   = tick16 && (sub_q == SUB_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      sub_q  <= '0;
    end else if (div_load) begin
      int_q  <= div_int;
      frac_q <= div_frac;
      cnt_q  <= '0;
      acc_q  <= '0;
      sub_q  <= '0;
    end else if (tick16) begin
      cnt_q  <= '0;
      acc_q  <= acc_sum[FRAC_W-1:0];
      sub_q  <= (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + SUB_W'(1);
    end else if (run) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              div_load,
  input logic              tick16,
  input logic              tick1,
  input logic [INT_W-1:0]  int_q,
  input logic [INT_W:0]    cnt_q,
  input logic [FRAC_W-1:0] acc_q
);
  assert_bit_with_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> tick16);

  assert_zero_int_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0) |-> !tick16);

  assert_paused_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick16);

  assert_paused_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !div_load) |=> $stable(cnt_q) && $stable(acc_q));

  assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> (cnt_q == '0) && (acc_q == '0));

  assert_load_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |-> !tick16 && !tick1);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q != '0) |-> (cnt_q <= {1'b0, int_q}));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && int_q >= INT_W'(2)) |=> !tick16);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .div_load(div_load),
  .tick16(tick16), .tick1(tick1),
  .int_q(int_q), .cnt_q(cnt_q), .acc_q(acc_q)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        div_load = 1'b0;
  logic        tick16, tick1;

  int checks = 0, errors = 0;
  int cycles = 0;
  int obs16 = 0, obs1 = 0;
  longint m_i = 0, m_f = 0, m_e = 0, m_n = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .div_int(div_int),
    .div_frac(div_frac), .div_load(div_load),
    .tick16(tick16), .tick1(tick1)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    bit e16, e1;
    cycles++;
    e16 = rst_n && en && !div_load && (m_i != 0) &&
          (m_e + 1 == (m_n + 1) * m_i + ((m_n + 1) * m_f) / 64);
    e1  = e16 && (((m_n + 1) % 16) == 0);
    if (!rst_n) chk("R1 tick16 in reset", tick16, 0);
    else if (div_load) chk("R7 tick16 on load", tick16, 0);
    else if (!en) chk("R6 tick16 paused", tick16, 0);
    else if (m_i == 0) chk("R5/R1 tick16 zero divisor", tick16, 0);
    else chk("R3 tick16 schedule", tick16, e16);
    chk("R4 tick1 schedule", tick1, e1);
    if (tick16) obs16++;
    if (tick1) obs1++;
    if (!rst_n) begin
      m_i = 0; m_f = 0; m_e = 0; m_n = 0;
    end else if (div_load) begin
      m_i = div_int; m_f = div_frac; m_e = 0; m_n = 0;
    end else if (en && m_i != 0) begin
      m_e++;
      if (e16) m_n++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(int i, int f);
    div_int = 16'(i); div_frac = 6'(f); div_load = 1'b1;
    step(1);
    div_load = 1'b0;
    obs16 = 0; obs1 = 0;
  endtask

  initial begin
    step(3);
    chk("R1 tick16 low in reset", tick16, 0);
    rst_n = 1'b1; en = 1'b1;
    step(20);
    chk("R1 no ticks before load", obs16, 0);

    load(4, 0);
    step(64);
    chk("R2 integer-only tick count", obs16, 16);
    chk("R4 bit ticks integer-only", obs1, 1);

    load(5, 21);
    step(64 * 5 + 21);
    chk("R3 64 ticks in 64*I+F cycles", obs16, 64);
    chk("R4 bit ticks over 64", obs1, 4);

    load(3, 63);
    step(64 * 3 + 62);
    chk("R3 one short of window", obs16, 63);

    load(1, 0);
    step(40);
    chk("R8 tick every cycle at I=1", obs16, 40);

    load(1, 63);
    step(127);
    chk("R3 I=1 F=63 window", obs16, 64);

    load(0, 17);
    step(300);
    chk("R5 zero integer silent", obs16, 0);

    load(7, 32);
    step(10);
    en = 1'b0;
    step(50);
    chk("R6 pause frozen count", obs16, 1);
    en = 1'b1;
    step(64 * 7 + 32 - 10);
    chk("R6 resume keeps position", obs16, 64);

    load(9, 1);
    step(13);
    load(6, 0);
    step(60);
    chk("R7 reload mid-period", obs16, 10);

    load(300, 1);
    for (int k = 0; k < 5; k++) begin
      en = 1'b0; step(3); en = 1'b1; step(97);
    end
    load(2, 32);
    step(200);
    chk("R8 I=2 F=32 tick count", obs16, 80);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule